// File: doc/BRIEF.md
# Tiered Code Read Protection Controller

This block settles, once per reset, how much access the outside world gets to a microcontroller's on-chip flash and debug port. Shortly after reset the boot logic reads a reserved protection word from flash and presents it with a one-cycle strobe. The controller decodes that word into one of four protection grades and holds the grade until the next reset. The only exception is a granted whole-device erase at the middle grade that allows only that erase, which lowers the grade to unprotected.

From the held grade the controller drives two enables: one for the debug port and one that lets an external boot pin force the serial boot loader. It also filters serial boot-loader commands. Each command is a read, a sector write, a sector erase or a whole-device erase, and each carries a sector index. The controller answers every command with a grant or a deny exactly one cycle later. Programming requests from the running application are always granted. The flash array, the serial port, the debug TAP and the command parser are outside the block.

Top module: `crp_ctrl`

## Requirements
- R1: While reset is asserted and before the first strobe, `level_valid`, `dbg_en`, `boot_ovr_en`, `isp_rsp_vld`, `isp_rsp_gnt` and `iap_rsp_gnt` are all 0.
- R2: The first `prot_word_vld` strobe after reset decodes `prot_word` as follows: 0x12345678 gives grade 1, 0x87654321 gives grade 2, 0x43218765 gives grade 3, and any other value gives grade 0. The result appears on `prot_level`, together with `level_valid`=1, in the cycle after the strobe.
- R3: Strobes after the first one have no effect on `prot_level`.
- R4: `dbg_en` is 1 only when `level_valid` is set and the grade is 0. `boot_ovr_en` is 1 only when `level_valid` is set and the grade is not 3.
- R5: `isp_rsp_vld` is 1 exactly in the cycle after a cycle with `isp_req_vld`=1. `isp_rsp_gnt` is 0 whenever `isp_rsp_vld` is 0.
- R6: A boot-loader request made while `level_valid` is 0 is denied.
- R7: At grade 0, every command is granted. The command codes are 0 read, 1 sector write, 2 sector erase and 3 whole-device erase.
- R8: At grade 1, read and whole-device erase are denied. A write or erase of sector 0 is denied. A write or erase of any other sector is granted.
- R9: At grade 2, only the whole-device erase (code 3) is granted.
- R10: A granted whole-device erase at grade 2 sets `prot_level` to 0 in the same cycle as its response, which also raises `dbg_en`.
- R11: At grade 3, every boot-loader command is denied and `boot_ovr_en` is 0.
- R12: `iap_rsp_gnt` is 1 exactly in the cycle after `iap_req_vld`=1, at every grade and before the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_word_vld | input | 1 | Strobe: protection word is valid |
| prot_word | input | 32 | Protection word read from flash |
| isp_req_vld | input | 1 | Boot-loader command request |
| isp_req_cmd | input | 2 | Command: 0 read, 1 write sector, 2 erase sector, 3 erase all |
| isp_req_sector | input | 4 | Target sector index |
| iap_req_vld | input | 1 | In-application programming request |
| isp_rsp_vld | output | 1 | Boot-loader response valid |
| isp_rsp_gnt | output | 1 | Boot-loader command granted |
| iap_rsp_gnt | output | 1 | In-application request granted |
| dbg_en | output | 1 | Debug port enable |
| boot_ovr_en | output | 1 | Boot-pin override enable |
| level_valid | output | 1 | Protection word has been sampled |
| prot_level | output | 2 | Current protection grade 0..3 |

## Verification
A wrongly decoded or lost grade shows in the cycle after the strobe on `prot_level`, `dbg_en` and `boot_ovr_en`, and it also shows in the grant of the very next boot-loader command. A wrong policy term is caught in the cycle after the offending request, because each response is compared against a behavioural model on every clock. A missed or spurious unlock after a whole-device erase shows in the response cycle itself, as a wrong grade and a wrong debug enable.

// File: rtl/crp_pkg.sv
package crp_pkg;
   typedef enum logic [1:0] {
      LVL_NONE  = 2'd0,
      LVL_ONE   = 2'd1,
      LVL_TWO   = 2'd2,
      LVL_THREE = 2'd3
   } crp_level_e;

   typedef enum logic [1:0] {
      CMD_READ       = 2'd0,
      CMD_WRITE      = 2'd1,
      CMD_ERASE_SECT = 2'd2,
      CMD_ERASE_ALL  = 2'd3
   } crp_cmd_e;
endpackage

// File: rtl/crp_level_reg.sv
module crp_level_reg
   import crp_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter logic [31:0] CODE_ONE    = 32'h1234_5678,
   parameter logic [31:0] CODE_TWO    = 32'h8765_4321,
   parameter logic [31:0] CODE_THREE  = 32'h4321_8765,
   parameter bit          ERASE_UNLOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  logic [WORD_W-1:0] word,
   input  logic              unlock_req,
   output logic              sampled,
   output crp_level_e        level
);
   localparam logic [WORD_W-1:0] K1 = WORD_W'(CODE_ONE);
   localparam logic [WORD_W-1:0] K2 = WORD_W'(CODE_TWO);
   localparam logic [WORD_W-1:0] K3 = WORD_W'(CODE_THREE);

   if (WORD_W < 2 || WORD_W > 32) begin : g_bad_width
      $error("crp_level_reg: WORD_W must be 2..32");
   end
   if (K1 == K2 || K2 == K3 || K1 == K3) begin : g_bad_codes
      $error("crp_level_reg: protection codes must differ");
   end

   function automatic crp_level_e decode(input logic [WORD_W-1:0] w);
      if (w == K1)      return LVL_ONE;
      else if (w == K2) return LVL_TWO;
      else if (w == K3) return LVL_THREE;
      else              return LVL_NONE;
   endfunction

   logic unlock_eff;
   if (ERASE_UNLOCK) begin : g_unlock
      assign unlock_eff = unlock_req;
   end else begin : g_no_unlock
      assign unlock_eff = unlock_req & 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sampled <= 1'b0;
         level   <= LVL_NONE;
      end else if (!sampled && word_vld) begin
         sampled <= 1'b1;
         level   <= decode(word);
      end else if (unlock_eff) begin
         level   <= LVL_NONE;
      end
   end
endmodule

// File: rtl/crp_cmd_filter.sv
module crp_cmd_filter
   import crp_pkg::*;
#(
   parameter int SECT_W    = 4,
   parameter int PROT_SECT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sampled,
   input  crp_level_e        level,
   input  logic              req_vld,
   input  crp_cmd_e          req_cmd,
   input  logic [SECT_W-1:0] req_sect,
   input  logic              iap_vld,
   output logic              rsp_vld,
   output logic              rsp_gnt,
   output logic              iap_gnt,
   output logic              unlock
);
   localparam int NUM_SECT = 1 << SECT_W;
   localparam logic [SECT_W-1:0] PROT_IDX = SECT_W'(PROT_SECT);

   if (SECT_W < 1 || SECT_W > 16) begin : g_bad_sect_w
      $error("crp_cmd_filter: SECT_W must be 1..16");
   end
   if (PROT_SECT < 0 || PROT_SECT >= NUM_SECT) begin : g_bad_prot
      $error("crp_cmd_filter: PROT_SECT out of range");
   end

   logic hits_prot;
   logic is_sector_op;
   logic allow;

   assign hits_prot    = (req_sect == PROT_IDX);
   assign is_sector_op = (req_cmd == CMD_WRITE) || (req_cmd == CMD_ERASE_SECT);

   always_comb begin
      allow = 1'b0;
      if (sampled) begin
         case (level)
            LVL_NONE:  allow = 1'b1;
            LVL_ONE:   allow = is_sector_op && !hits_prot;
            LVL_TWO:   allow = (req_cmd == CMD_ERASE_ALL);
            default:   allow = 1'b0;
         endcase
      end
   end

   assign unlock = req_vld && allow && (level == LVL_TWO) && (req_cmd == CMD_ERASE_ALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         rsp_gnt <= 1'b0;
         iap_gnt <= 1'b0;
      end else begin
         rsp_vld <= req_vld;
         rsp_gnt <= req_vld && allow;
         iap_gnt <= iap_vld;
      end
   end
endmodule

// File: rtl/crp_access_gate.sv
module crp_access_gate
   import crp_pkg::*;
(
   input  logic       sampled,
   input  crp_level_e level,
   output logic       dbg_en,
   output logic       boot_ovr_en
);
   assign dbg_en      = sampled && (level == LVL_NONE);
   assign boot_ovr_en = sampled && (level != LVL_THREE);
endmodule

// File: rtl/crp_ctrl.sv
module crp_ctrl
   import crp_pkg::*;
#(
   parameter int          WORD_W       = 32,
   parameter int          SECT_W       = 4,
   parameter int          PROT_SECT    = 0,
   parameter logic [31:0] CODE_ONE     = 32'h1234_5678,
   parameter logic [31:0] CODE_TWO     = 32'h8765_4321,
   parameter logic [31:0] CODE_THREE   = 32'h4321_8765,
   parameter bit          ERASE_UNLOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_word_vld,
   input  logic [WORD_W-1:0] prot_word,
   input  logic              isp_req_vld,
   input  logic [1:0]        isp_req_cmd,
   input  logic [SECT_W-1:0] isp_req_sector,
   input  logic              iap_req_vld,
   output logic              isp_rsp_vld,
   output logic              isp_rsp_gnt,
   output logic              iap_rsp_gnt,
   output logic              dbg_en,
   output logic              boot_ovr_en,
   output logic              level_valid,
   output logic [1:0]        prot_level
);
   crp_level_e lvl;
   logic       unlock;

   crp_level_reg #(
      .WORD_W      (WORD_W),
      .CODE_ONE    (CODE_ONE),
      .CODE_TWO    (CODE_TWO),
      .CODE_THREE  (CODE_THREE),
      .ERASE_UNLOCK(ERASE_UNLOCK)
   ) level_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_vld  (prot_word_vld),
      .word      (prot_word),
      .unlock_req(unlock),
      .sampled   (level_valid),
      .level     (lvl)
   );

   crp_cmd_filter #(
      .SECT_W   (SECT_W),
      .PROT_SECT(PROT_SECT)
   ) filter_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sampled (level_valid),
      .level   (lvl),
      .req_vld (isp_req_vld),
      .req_cmd (crp_cmd_e'(isp_req_cmd)),
      .req_sect(isp_req_sector),
      .iap_vld (iap_req_vld),
      .rsp_vld (isp_rsp_vld),
      .rsp_gnt (isp_rsp_gnt),
      .iap_gnt (iap_rsp_gnt),
      .unlock  (unlock)
   );

   crp_access_gate gate_i (
      .sampled    (level_valid),
      .level      (lvl),
      .dbg_en     (dbg_en),
      .boot_ovr_en(boot_ovr_en)
   );

   assign prot_level = lvl;
endmodule

// File: rtl/crp_ctrl_chk.sv
module crp_ctrl_chk #(
   parameter int SECT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              isp_req_vld,
   input logic [SECT_W-1:0] isp_req_sector,
   input logic              iap_req_vld,
   input logic              isp_rsp_vld,
   input logic              isp_rsp_gnt,
   input logic              iap_rsp_gnt,
   input logic              dbg_en,
   input logic              boot_ovr_en,
   input logic              level_valid,
   input logic [1:0]        prot_level
);
   // R5
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isp_req_vld |=> isp_rsp_vld);
   // R5
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !isp_req_vld |=> !isp_rsp_vld && !isp_rsp_gnt);
   // R3
   level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_valid |=> level_valid &&
         ((prot_level == $past(prot_level)) || ($past(prot_level) == 2'd2 && prot_level == 2'd0)));
   // R4
   dbg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_level != 2'd0) |-> !dbg_en);
   // R1
   unsampled_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !level_valid |-> !dbg_en && !boot_ovr_en);
   // R6
   unsampled_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isp_req_vld && !level_valid) |=> !isp_rsp_gnt);
   // R11
   top_level_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_valid && prot_level == 2'd3) |-> !boot_ovr_en && !isp_rsp_gnt);
   // R8
   sector_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isp_req_vld && level_valid && prot_level == 2'd1 && isp_req_sector == '0) |=> !isp_rsp_gnt);
   // R12
   iap_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iap_req_vld |=> iap_rsp_gnt);
endmodule

bind crp_ctrl crp_ctrl_chk #(.SECT_W(SECT_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .isp_req_vld   (isp_req_vld),
   .isp_req_sector(isp_req_sector),
   .iap_req_vld   (iap_req_vld),
   .isp_rsp_vld   (isp_rsp_vld),
   .isp_rsp_gnt   (isp_rsp_gnt),
   .iap_rsp_gnt   (iap_rsp_gnt),
   .dbg_en        (dbg_en),
   .boot_ovr_en   (boot_ovr_en),
   .level_valid   (level_valid),
   .prot_level    (prot_level)
);

// File: tb/crp_ctrl_tb_top.sv
module crp_ctrl_tb_top;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prot_word_vld = 1'b0;
   logic [31:0]   prot_word = '0;
   logic          isp_req_vld = 1'b0;
   logic [1:0]    isp_req_cmd = '0;
   logic [SW-1:0] isp_req_sector = '0;
   logic          iap_req_vld = 1'b0;
   logic          isp_rsp_vld, isp_rsp_gnt, iap_rsp_gnt, dbg_en, boot_ovr_en, level_valid;
   logic [1:0]    prot_level;

   always #2 clk = ~clk;

   crp_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .prot_word_vld(prot_word_vld), .prot_word(prot_word),
      .isp_req_vld(isp_req_vld), .isp_req_cmd(isp_req_cmd), .isp_req_sector(isp_req_sector),
      .iap_req_vld(iap_req_vld), .isp_rsp_vld(isp_rsp_vld), .isp_rsp_gnt(isp_rsp_gnt),
      .iap_rsp_gnt(iap_rsp_gnt), .dbg_en(dbg_en), .boot_ovr_en(boot_ovr_en),
      .level_valid(level_valid), .prot_level(prot_level)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R7";

   // behavioural reference model
   bit m_valid, m_rsp_vld, m_rsp_gnt, m_iap;
   int m_level;

   function automatic bit policy(bit valid, int lvl, int cmd, int sect);
      if (!valid) return 0;
      if (lvl == 0) return 1;
      if (lvl == 1) return (cmd == 1 || cmd == 2) && sect != 0;
      if (lvl == 2) return cmd == 3;
      return 0;
   endfunction

   function automatic int grade_of(logic [31:0] w);
      if (w == 32'h1234_5678) return 1;
      if (w == 32'h8765_4321) return 2;
      if (w == 32'h4321_8765) return 3;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 0; m_level <= 0; m_rsp_vld <= 0; m_rsp_gnt <= 0; m_iap <= 0;
      end else begin
         bit g;
         g = policy(m_valid, m_level, int'(isp_req_cmd), int'(isp_req_sector));
         m_rsp_vld <= isp_req_vld;
         m_rsp_gnt <= isp_req_vld && g;
         m_iap     <= iap_req_vld;
         if (!m_valid && prot_word_vld) begin
            m_valid <= 1; m_level <= grade_of(prot_word);
         end else if (isp_req_vld && g && isp_req_cmd == 2'd3 && m_level == 2) begin
            m_level <= 0;
         end
      end
   end

   task automatic check(string req, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R5", int'(isp_rsp_vld), int'(m_rsp_vld), "rsp_vld");
         check(tag, int'(isp_rsp_gnt), int'(m_rsp_gnt), "rsp_gnt");
         check("R12", int'(iap_rsp_gnt), int'(m_iap), "iap_gnt");
         check("R2", int'(level_valid), int'(m_valid), "level_valid");
         check(tag, int'(prot_level), m_level, "prot_level");
         check("R4", int'(dbg_en), int'(m_valid && m_level == 0), "dbg_en");
         check("R4", int'(boot_ovr_en), int'(m_valid && m_level != 3), "boot_ovr_en");
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: closed state while in reset
      check("R1", int'(level_valid), 0, "level_valid in reset");
      check("R1", int'(dbg_en), 0, "dbg_en in reset");
      check("R1", int'(boot_ovr_en), 0, "boot_ovr_en in reset");
      check("R1", int'(isp_rsp_vld || isp_rsp_gnt || iap_rsp_gnt), 0, "responses in reset");
      rst_n = 1'b1;
   endtask

   task automatic sample(logic [31:0] w, int exp_lvl, string req);
      @(negedge clk);
      prot_word_vld = 1'b1; prot_word = w;
      @(negedge clk);
      prot_word_vld = 1'b0; prot_word = '0;
      check(req, int'(prot_level), exp_lvl, "decoded level");
      check(req, int'(level_valid), 1, "level_valid after strobe");
   endtask

   task automatic isp(int cmd, int sect, int exp_gnt, string req);
      @(negedge clk);
      isp_req_vld = 1'b1; isp_req_cmd = 2'(cmd); isp_req_sector = SW'(sect);
      @(negedge clk);
      isp_req_vld = 1'b0;
      check("R5", int'(isp_rsp_vld), 1, "response one cycle later");
      check(req, int'(isp_rsp_gnt), exp_gnt, $sformatf("grant cmd %0d sect %0d", cmd, sect));
   endtask

   task automatic iap(string req);
      @(negedge clk);
      iap_req_vld = 1'b1;
      @(negedge clk);
      iap_req_vld = 1'b0;
      check(req, int'(iap_rsp_gnt), 1, "iap grant");
   endtask

   bit done = 0;
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R6: denied before sampling
      tag = "R6";
      isp(0, 3, 0, "R6");
      isp(3, 0, 0, "R6");
      iap("R12");
      // R7: unprotected
      tag = "R7";
      sample(32'h0000_0000, 0, "R2");
      check("R4", int'(dbg_en), 1, "dbg_en grade 0");
      for (int c = 0; c < 4; c++) isp(c, 0, 1, "R7");
      isp(2, 9, 1, "R7");
      // R3: later strobe ignored
      tag = "R3";
      sample(32'h4321_8765, 0, "R3");
      isp(0, 1, 1, "R3");

      // R8: grade 1
      do_reset();
      tag = "R8";
      sample(32'h1234_5678, 1, "R2");
      check("R4", int'(dbg_en), 0, "dbg_en grade 1");
      check("R4", int'(boot_ovr_en), 1, "boot_ovr_en grade 1");
      isp(0, 5, 0, "R8");
      isp(1, 0, 0, "R8");
      isp(1, 5, 1, "R8");
      isp(2, 0, 0, "R8");
      isp(2, 15, 1, "R8");
      isp(3, 4, 0, "R8");
      iap("R12");

      // R9 / R10: grade 2
      do_reset();
      tag = "R9";
      sample(32'h8765_4321, 2, "R2");
      isp(0, 2, 0, "R9");
      isp(1, 2, 0, "R9");
      isp(2, 2, 0, "R9");
      check("R9", int'(prot_level), 2, "grade kept after denials");
      tag = "R10";
      isp(3, 0, 1, "R10");
      check("R10", int'(prot_level), 0, "unlocked after erase all");
      check("R10", int'(dbg_en), 1, "dbg_en after erase all");
      isp(1, 0, 1, "R10");

      // R11: grade 3
      do_reset();
      tag = "R11";
      sample(32'h4321_8765, 3, "R2");
      check("R11", int'(boot_ovr_en), 0, "boot_ovr_en grade 3");
      for (int c = 0; c < 4; c++) isp(c, 7, 0, "R11");
      iap("R12");

      // R2: near-miss code is unprotected
      do_reset();
      tag = "R2";
      sample(32'h1234_5679, 0, "R2");
      isp(0, 0, 1, "R2");

      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule